// File: doc/BRIEF.md
# SPI-Mode Card Sector Reader

This block fetches one sector from a memory card that is driven in its SPI mode. On a start pulse it latches a sector number and selects the card. It then issues the single-block read command and polls for the one-byte command response. Next it waits for the data start token and streams every byte of the sector to the consumer, one byte per valid strobe. After the data it clocks out the two CRC bytes and one spare byte, then runs a fixed deselect sequence. The outcome is reported as a one-cycle done pulse together with a 3-bit result code.

All card traffic is byte-granular. Each byte is eight SCLK periods, and each SCLK half-period lasts a parameterised number of system clocks, so the serial rate fits slow bring-up clocking. Every polling loop has a parameterised upper bound, and each bound has its own result code. A consumer that loses interest can raise `halt`. Delivery then stops, but the block still clocks out the whole sector so that the card ends in a clean state.

Top module: `spi_sector_reader`

## Requirements
- R1: A `start` seen while a read is under way is refused: within two cycles `done` pulses with `err` = 4 (pending), and the running read carries on to its normal completion without change.
- R2: Selection gives 8 SCLK periods with `cs_n` high and MOSI high, then drives `cs_n` low with SCLK low. It then reads bytes with MOSI high until 0xFF arrives. After `BUSY_TRIES` reads without 0xFF the result is code 3 (busy).
- R3: The command is 6 bytes: 0x51, then the upper, middle and low byte of the sector number shifted left by one, then 0x00, then 0x01. Together these form the byte address sector×512.
- R4: The response is found by reading bytes with MOSI high until bit 7 is clear, for at most `RESP_TRIES` reads. A last-read value that is nonzero gives code 1 (command error).
- R5: After a zero response, bytes are read until 0xFE arrives. After `TOKEN_TRIES` reads without it the result is code 2 (timeout).
- R6: After the token, the `SECTOR_BYTES` data bytes appear on `rd_data` in card order. Each is marked by a one-cycle `rd_valid` pulse, and `rd_valid` is only ever high while `cs_n` is low.
- R7: Once `halt` has been high during a read, no further `rd_valid` occurs. The card still receives the full sector plus 24 more SCLK periods (CRC and one spare byte) before deselection.
- R8: Every read, whatever its result, ends with 8 SCLK periods with `cs_n` low and MOSI high, then `cs_n` high, then 8 more SCLK periods. MOSI is high whenever `cs_n` is high.
- R9: Bytes move most significant bit first. MOSI changes only while SCLK is low, MISO is sampled when SCLK rises, SCLK idles low, and each SCLK half-period lasts `CLK_HALF` system clocks.
- R10: `done` pulses for one cycle per finished read, with `err` = 0 on success. `err` is 0 in every cycle where `done` is low. The codes are 0 ok, 1 command error, 2 timeout, 3 busy, 4 pending.
- R11: After reset `cs_n` and MOSI are high, SCLK is low, and `done` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to read a sector |
| sector | input | 23 | Sector number, latched with an accepted start |
| halt | input | 1 | Consumer no longer wants data; the remaining bytes are clocked as dummies |
| miso | input | 1 | Serial data from the card |
| cs_n | output | 1 | Card select, active low |
| sclk | output | 1 | Serial clock to the card |
| mosi | output | 1 | Serial data to the card |
| rd_data | output | 8 | Sector data byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| done | output | 1 | One-cycle pulse when a read finishes or a start is refused |
| err | output | 3 | Result code, valid with `done` |

## Verification
Some rules must hold in every cycle, and the assertions check these: MOSI high while the card is deselected, MOSI held steady across each SCLK high phase, SCLK low when select falls, data strobes only while selected and never in two adjacent cycles, and a zero code outside done pulses. The bench checks the rest against a card model whose busy, response and token delays it sweeps through and beyond each polling limit. From its own arithmetic it predicts the exact command bytes, the data order, the number of SCLK periods with select high and low, and the result code. Only these scenarios can show the halt behaviour, the refusal of a second start while the first read still completes, and the full CRC and deselect clocking after an error or an early stop.

// File: rtl/spi_sec_pkg.sv
// Shared types and constants for the SPI-mode sector reader.
// Assumes byte-granular card traffic; all codes fit in 3 bits.
package spi_sec_pkg;

    localparam int SEC_W = 23;
    localparam logic [7:0] CMD_READ_ONE = 8'h51;
    localparam logic [7:0] DATA_TOKEN   = 8'hFE;
    localparam logic [7:0] FILL_BYTE    = 8'hFF;
    localparam int FRAME_BYTES = 6;
    localparam int TAIL_BYTES  = 3;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_CMD     = 3'd1,
        ERR_TIMEOUT = 3'd2,
        ERR_BUSY    = 3'd3,
        ERR_PENDING = 3'd4
    } err_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SEL_PRE,
        PH_SEL_POLL,
        PH_CMD,
        PH_RESP,
        PH_TOKEN,
        PH_DATA,
        PH_TAIL,
        PH_DSEL_LO,
        PH_DSEL_HI
    } phase_e;

endpackage

// File: rtl/spi_sec_shifter.sv
// Byte shifter: moves one byte over SCLK/MOSI/MISO, most significant bit first.
// Each SCLK half-period lasts CLK_HALF system clocks. MISO is sampled at the
// clock edge that raises SCLK. MOSI is high and SCLK low while idle.
// Assumes go is only raised while the shifter is idle.
module spi_sec_shifter #(
    parameter int CLK_HALF = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int DIV_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_HALF - 1);

    logic             active_q;
    logic             sclk_q;
    logic             mosi_q;
    logic             done_q;
    logic [7:0]       tx_q;
    logic [7:0]       rx_q;
    logic [2:0]       bit_q;
    logic [DIV_W-1:0] div_q;

    // Purpose: run the half-period divider and the eight-bit shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            mosi_q   <= 1'b1;
            done_q   <= 1'b0;
            tx_q     <= '0;
            rx_q     <= '0;
            bit_q    <= '0;
            div_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                sclk_q <= 1'b0;
                mosi_q <= 1'b1;
                if (go) begin
                    active_q <= 1'b1;
                    tx_q     <= tx_byte;
                    mosi_q   <= tx_byte[7];
                    bit_q    <= '0;
                    div_q    <= '0;
                end
            end else if (div_q == DIV_LAST) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                        mosi_q   <= 1'b1;
                    end else begin
                        bit_q  <= bit_q + 3'd1;
                        tx_q   <= {tx_q[6:0], 1'b0};
                        mosi_q <= tx_q[6];
                    end
                end
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = mosi_q;
    assign done    = done_q;
    assign rx_byte = rx_q;

endmodule

// File: rtl/spi_sec_frame.sv
// Command frame builder: returns byte idx of the single-block read command
// for a sector. The address bytes carry the sector shifted left by one, so
// that together with the trailing zero byte the address is sector*512.
module spi_sec_frame
    import spi_sec_pkg::*;
(
    input  logic [SEC_W-1:0] sector,
    input  logic [2:0]       idx,
    output logic [7:0]       frame_byte
);
    logic [SEC_W:0] addr_hi;

    assign addr_hi = {sector, 1'b0};

    // Purpose: select the frame byte for the current index.
    always_comb begin
        unique case (idx)
            3'd0:    frame_byte = CMD_READ_ONE;
            3'd1:    frame_byte = addr_hi[23:16];
            3'd2:    frame_byte = addr_hi[15:8];
            3'd3:    frame_byte = addr_hi[7:0];
            3'd4:    frame_byte = 8'h00;
            default: frame_byte = 8'h01;
        endcase
    end

endmodule

// File: rtl/spi_sec_seq.sv
// Read sequencer: walks select, command, response, token, data, tail and
// deselect, one shifter byte at a time. Owns chip select, the polling
// bounds and the result code. Assumes the shifter reports each byte with
// a one-cycle done and is idle in the following cycle.
module spi_sec_seq
    import spi_sec_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int BUSY_TRIES   = 65535,
    parameter int RESP_TRIES   = 255,
    parameter int TOKEN_TRIES  = 65536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEC_W-1:0] sector,
    input  logic             halt,
    input  logic             x_done,
    input  logic [7:0]       x_rx,
    input  logic [7:0]       cmd_byte,
    output logic             x_go,
    output logic [7:0]       x_tx,
    output logic [2:0]       cmd_idx,
    output logic [SEC_W-1:0] sec_lat,
    output logic             cs_n,
    output logic             busy,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic [2:0]       err
);
    localparam int M1 = (SECTOR_BYTES > BUSY_TRIES) ? SECTOR_BYTES : BUSY_TRIES;
    localparam int M2 = (RESP_TRIES > TOKEN_TRIES) ? RESP_TRIES : TOKEN_TRIES;
    localparam int M3 = (M1 > M2) ? M1 : M2;
    localparam int CNT_MAX = (M3 > 8) ? M3 : 8;
    localparam int CNT_W = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] BUSY_LAST  = CNT_W'(BUSY_TRIES - 1);
    localparam logic [CNT_W-1:0] RESP_LAST  = CNT_W'(RESP_TRIES - 1);
    localparam logic [CNT_W-1:0] TOKEN_LAST = CNT_W'(TOKEN_TRIES - 1);
    localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(SECTOR_BYTES - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BYTES - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST  = CNT_W'(TAIL_BYTES - 1);

    phase_e           st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    err_e             err_q, err_d;
    logic             wait_q;
    logic             drop_q;
    logic             cs_n_q;
    logic             done_q;
    logic             rdv_q;
    logic [7:0]       rdd_q;
    logic [SEC_W-1:0] sec_q;
    logic             fin;
    logic             deliver;

    // Purpose: decide the next phase, counter and result from each finished byte.
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        err_d   = err_q;
        fin     = 1'b0;
        deliver = 1'b0;
        if (st_q == PH_IDLE) begin
            if (start) begin
                st_d  = PH_SEL_PRE;
                cnt_d = '0;
                err_d = ERR_NONE;
            end
        end else if (x_done) begin
            unique case (st_q)
                PH_SEL_PRE: begin
                    st_d  = PH_SEL_POLL;
                    cnt_d = '0;
                end
                PH_SEL_POLL: begin
                    if (x_rx == FILL_BYTE) begin
                        st_d  = PH_CMD;
                        cnt_d = '0;
                    end else if (cnt_q == BUSY_LAST) begin
                        err_d = ERR_BUSY;
                        st_d  = PH_DSEL_LO;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                PH_CMD: begin
                    if (cnt_q == FRAME_LAST) begin
                        st_d  = PH_RESP;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                PH_RESP: begin
                    if (!x_rx[7] || cnt_q == RESP_LAST) begin
                        cnt_d = '0;
                        if (x_rx != 8'h00) begin
                            err_d = ERR_CMD;
                            st_d  = PH_DSEL_LO;
                        end else begin
                            st_d = PH_TOKEN;
                        end
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                PH_TOKEN: begin
                    if (x_rx == DATA_TOKEN) begin
                        st_d  = PH_DATA;
                        cnt_d = '0;
                    end else if (cnt_q == TOKEN_LAST) begin
                        err_d = ERR_TIMEOUT;
                        st_d  = PH_DSEL_LO;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                PH_DATA: begin
                    deliver = !(drop_q || halt);
                    if (cnt_q == DATA_LAST) begin
                        st_d  = PH_TAIL;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                PH_TAIL: begin
                    if (cnt_q == TAIL_LAST) begin
                        st_d = PH_DSEL_LO;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                PH_DSEL_LO: st_d = PH_DSEL_HI;
                PH_DSEL_HI: begin
                    st_d = PH_IDLE;
                    fin  = 1'b1;
                end
                default: st_d = PH_IDLE;
            endcase
        end
    end

    // Purpose: register phase, counters, select line and consumer outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= PH_IDLE;
            cnt_q  <= '0;
            err_q  <= ERR_NONE;
            wait_q <= 1'b0;
            drop_q <= 1'b0;
            cs_n_q <= 1'b1;
            done_q <= 1'b0;
            rdv_q  <= 1'b0;
            rdd_q  <= '0;
            sec_q  <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            err_q  <= err_d;
            done_q <= fin;
            rdv_q  <= deliver;
            cs_n_q <= (st_d == PH_IDLE) || (st_d == PH_SEL_PRE) || (st_d == PH_DSEL_HI);
            if (x_go) begin
                wait_q <= 1'b1;
            end else if (x_done) begin
                wait_q <= 1'b0;
            end
            if (deliver) begin
                rdd_q <= x_rx;
            end
            if (st_q == PH_IDLE && start) begin
                sec_q  <= sector;
                drop_q <= 1'b0;
            end else if (st_q != PH_IDLE && halt) begin
                drop_q <= 1'b1;
            end
        end
    end

    assign x_go     = (st_q != PH_IDLE) && !wait_q;
    assign x_tx     = (st_q == PH_CMD) ? cmd_byte : FILL_BYTE;
    assign cmd_idx  = cnt_q[2:0];
    assign sec_lat  = sec_q;
    assign cs_n     = cs_n_q;
    assign busy     = (st_q != PH_IDLE);
    assign rd_data  = rdd_q;
    assign rd_valid = rdv_q;
    assign done     = done_q;
    assign err      = err_q;

endmodule

// File: rtl/spi_sector_reader.sv
// Top of the SPI-mode sector reader. Joins the sequencer, the command frame
// builder and the byte shifter, and answers a start that arrives during a
// read with a pending result. A refusal that collides with the read's own
// done pulse is held and reported in the next cycle.
module spi_sector_reader
    import spi_sec_pkg::*;
#(
    parameter int CLK_HALF     = 125,
    parameter int SECTOR_BYTES = 512,
    parameter int BUSY_TRIES   = 65535,
    parameter int RESP_TRIES   = 255,
    parameter int TOKEN_TRIES  = 65536
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [22:0] sector,
    input  logic        halt,
    input  logic        miso,
    output logic        cs_n,
    output logic        sclk,
    output logic        mosi,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    output logic        done,
    output logic [2:0]  err
);
    logic             x_go;
    logic             x_done;
    logic [7:0]       x_tx;
    logic [7:0]       x_rx;
    logic [7:0]       cmd_byte;
    logic [2:0]       cmd_idx;
    logic [SEC_W-1:0] sec_lat;
    logic             seq_busy;
    logic             seq_done;
    logic [2:0]       seq_err;
    logic             rej_q;

    spi_sec_seq #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .BUSY_TRIES   (BUSY_TRIES),
        .RESP_TRIES   (RESP_TRIES),
        .TOKEN_TRIES  (TOKEN_TRIES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .sector   (sector),
        .halt     (halt),
        .x_done   (x_done),
        .x_rx     (x_rx),
        .cmd_byte (cmd_byte),
        .x_go     (x_go),
        .x_tx     (x_tx),
        .cmd_idx  (cmd_idx),
        .sec_lat  (sec_lat),
        .cs_n     (cs_n),
        .busy     (seq_busy),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .done     (seq_done),
        .err      (seq_err)
    );

    spi_sec_frame u_frame (
        .sector     (sec_lat),
        .idx        (cmd_idx),
        .frame_byte (cmd_byte)
    );

    spi_sec_shifter #(
        .CLK_HALF (CLK_HALF)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (x_go),
        .tx_byte (x_tx),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .done    (x_done),
        .rx_byte (x_rx)
    );

    // Purpose: hold a refused start until the done channel is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rej_q <= 1'b0;
        end else begin
            rej_q <= (start && seq_busy) || (rej_q && seq_done);
        end
    end

    assign done = seq_done || rej_q;
    assign err  = seq_done ? seq_err : (rej_q ? ERR_PENDING : ERR_NONE);

endmodule

// File: rtl/spi_sector_reader_chk.sv
// Cycle-level rules of the sector reader's pins, bound to every instance.
module spi_sector_reader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic       mosi,
    input logic       rd_valid,
    input logic       done,
    input logic [2:0] err
);
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (err == 3'd0));

    p_code_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err <= 3'd4));

    p_mosi_high_unselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> mosi);

    p_mosi_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    p_select_sclk_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (!sclk && !$past(sclk)));

    p_valid_selected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !cs_n);

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

bind spi_sector_reader spi_sector_reader_chk u_chk (.*);

// File: tb/spi_sector_reader_test.sv
// Bench: card model with adjustable busy, response and token delays; sweeps
// each delay across its polling limit and checks clocking and results.
module spi_sector_reader_test;
    localparam int HALF = 2;
    localparam int SB   = 8;
    localparam int BT   = 4;
    localparam int RT   = 3;
    localparam int TT   = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [22:0] sector;
    logic        halt;
    logic        miso;
    logic        cs_n, sclk, mosi, rd_valid, done;
    logic [7:0]  rd_data;
    logic [2:0]  err;

    always #4 clk = ~clk;

    spi_sector_reader #(
        .CLK_HALF (HALF), .SECTOR_BYTES (SB), .BUSY_TRIES (BT),
        .RESP_TRIES (RT), .TOKEN_TRIES (TT)
    ) uut (
        .clk (clk), .rst_n (rst_n), .start (start), .sector (sector),
        .halt (halt), .miso (miso), .cs_n (cs_n), .sclk (sclk), .mosi (mosi),
        .rd_data (rd_data), .rd_valid (rd_valid), .done (done), .err (err)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    int sc_busy, sc_resp, sc_tok, seed;
    logic [7:0] sc_r1;

    int lo_edges = 0, hi_edges = 0, hi_at_fall = 0;
    logic [7:0] cap [0:63];
    logic [7:0] got [0:15];
    int ngot = 0;
    int dn_n = 0;
    int dn_err [0:3];
    int hi_run = 0, hi_min = 1000, hi_max = 0;

    function automatic logic [7:0] data_at(int d);
        return 8'((d * 37 + seed) & 255);
    endfunction

    function automatic logic [7:0] card_byte(int k);
        int k2, k3, d;
        if (k < sc_busy) return 8'h00;
        if (k == sc_busy) return 8'hFF;
        k2 = k - sc_busy - 7;
        if (k2 < 0) return 8'hFF;
        if (k2 < sc_resp) return 8'hFF;
        if (k2 == sc_resp) return sc_r1;
        k3 = k2 - sc_resp - 1;
        if (k3 < sc_tok) return 8'hFF;
        if (k3 == sc_tok) return 8'hFE;
        d = k3 - sc_tok - 1;
        if (d < SB) return data_at(d);
        return 8'hFF;
    endfunction

    function automatic logic card_bit(int n);
        logic [7:0] v;
        v = card_byte(n >> 3);
        return v[7 - (n & 7)];
    endfunction

    always_comb miso = cs_n ? 1'b1 : card_bit(lo_edges);

    always @(negedge cs_n) begin
        hi_at_fall = hi_edges;
        lo_edges   = 0;
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            if ((lo_edges >> 3) < 64) cap[lo_edges >> 3][7 - (lo_edges & 7)] = mosi;
            lo_edges = lo_edges + 1;
        end else begin
            hi_edges = hi_edges + 1;
        end
    end

    always @(negedge clk) begin
        if (rd_valid) begin
            if (ngot < 16) got[ngot] = rd_data;
            ngot = ngot + 1;
        end
        if (done) begin
            if (dn_n < 4) dn_err[dn_n] = int'(err);
            dn_n = dn_n + 1;
        end
        if (sclk) hi_run = hi_run + 1;
        else if (hi_run > 0) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 190000) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests = n_tests + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic verify(input logic [22:0] sec, input int halt_after, input bit rej);
        int polls_b, rp, tp, low_bytes, exp_err, exp_n, base, bad, cmd0;
        logic [23:0] s2;
        logic [7:0] frame [0:5];
        bit rfail;
        s2 = {sec, 1'b0};
        frame[0] = 8'h51; frame[1] = s2[23:16]; frame[2] = s2[15:8];
        frame[3] = s2[7:0]; frame[4] = 8'h00; frame[5] = 8'h01;
        polls_b = (sc_busy >= BT) ? BT : sc_busy + 1;
        rp = (sc_resp >= RT) ? RT : sc_resp + 1;
        tp = (sc_tok >= TT) ? TT : sc_tok + 1;
        rfail = (sc_resp >= RT) || (sc_r1 != 8'h00);
        base = polls_b + 6;
        if (sc_busy >= BT) begin
            exp_err = 3; low_bytes = polls_b + 1;
        end else if (rfail) begin
            exp_err = 1; low_bytes = base + rp + 1;
        end else if (sc_tok >= TT) begin
            exp_err = 2; low_bytes = base + rp + tp + 1;
        end else begin
            exp_err = 0; low_bytes = base + rp + tp + SB + 3 + 1;
        end
        exp_n = (exp_err != 0) ? 0 : ((halt_after >= 0 && halt_after < SB) ? halt_after : SB);
        if (rej) begin
            chk(dn_n == 2, "R1 done count with refusal", dn_n, 2);
            chk(dn_err[0] == 4, "R1 refusal code", dn_err[0], 4);
            chk(dn_err[1] == exp_err, "R1 read result after refusal", dn_err[1], exp_err);
        end else begin
            chk(dn_n == 1, "R10 one done pulse", dn_n, 1);
            chk(dn_err[0] == exp_err, "R10 result code", dn_err[0], exp_err);
        end
        chk(ngot == exp_n, "R6/R7 delivered byte count", ngot, exp_n);
        for (int i = 0; i < exp_n && i < 16; i++)
            chk(got[i] == data_at(i), "R6/R9 data byte", int'(got[i]), int'(data_at(i)));
        chk(hi_at_fall == 8, "R2 clocks before select", hi_at_fall, 8);
        chk(hi_edges == 16, "R8 clocks with select high", hi_edges, 16);
        chk(lo_edges == 8 * low_bytes, "R7/R8 clocks with select low", lo_edges, 8 * low_bytes);
        cmd0 = (sc_busy >= BT) ? 1000 : polls_b;
        bad = 0;
        for (int k = 0; k < low_bytes && k < 64; k++)
            if (!(k >= cmd0 && k < cmd0 + 6) && cap[k] != 8'hFF) bad = bad + 1;
        chk(bad == 0, "R2/R4/R8 MOSI high outside command", bad, 0);
        if (sc_busy < BT)
            for (int j = 0; j < 6; j++)
                chk(cap[cmd0 + j] == frame[j], "R3 command byte", int'(cap[cmd0 + j]), int'(frame[j]));
    endtask

    task automatic run_op(input logic [22:0] sec, input int halt_after, input int rej_at);
        int want;
        want = (rej_at >= 0) ? 2 : 1;
        hi_edges = 0; ngot = 0; dn_n = 0;
        for (int k = 0; k < 64; k++) cap[k] = 8'h00;
        @(negedge clk); start = 1'b1; sector = sec;
        @(negedge clk); start = 1'b0; sector = ~sec;
        for (int c = 0; c < 20000 && dn_n < want; c++) begin
            @(negedge clk);
            start = (c == rej_at);
            if (halt_after >= 0 && ngot >= halt_after) halt = 1'b1;
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
        halt = 1'b0;
        verify(sec, halt_after, rej_at >= 0);
    endtask

    task automatic set_card(input int b, input int r, input int t, input logic [7:0] r1, input int s);
        sc_busy = b; sc_resp = r; sc_tok = t; sc_r1 = r1; seed = s;
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; halt = 1'b0; sector = '0;
        set_card(0, 0, 0, 8'h00, 0);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R11 cs_n after reset", int'(cs_n), 1);
        chk(sclk == 1'b0, "R11 sclk after reset", int'(sclk), 0);
        chk(mosi == 1'b1, "R11 mosi after reset", int'(mosi), 1);
        chk(done == 1'b0 && rd_valid == 1'b0, "R11 strobes after reset", int'({done, rd_valid}), 0);

        // R2 and R4: busy and response delays swept across their limits.
        for (int b = 0; b <= BT; b++)
            for (int r = 0; r <= RT; r++) begin
                set_card(b, r, 1, 8'h00, b * 16 + r);
                run_op(23'h12345 + 23'(b), -1, -1);
            end
        // R5: token delay swept across its limit.
        for (int t = 0; t <= TT; t++) begin
            set_card(1, 1, t, 8'h00, 100 + t);
            run_op(23'h0ABCDE, -1, -1);
        end
        // R3: sector address extremes.
        set_card(0, 0, 0, 8'h00, 7);
        run_op(23'h000000, -1, -1);
        run_op(23'h7FFFFF, -1, -1);
        run_op(23'h400001, -1, -1);
        run_op(23'h2AAAAA, -1, -1);
        // R4: nonzero responses.
        set_card(0, 1, 0, 8'h01, 9);  run_op(23'h10, -1, -1);
        set_card(0, 0, 0, 8'h04, 9);  run_op(23'h11, -1, -1);
        set_card(2, 2, 0, 8'h7F, 9);  run_op(23'h12, -1, -1);
        // R7: early stop at several points.
        set_card(1, 0, 1, 8'h00, 55); run_op(23'h222, 0, -1);
        set_card(1, 0, 1, 8'h00, 56); run_op(23'h223, 3, -1);
        set_card(1, 0, 1, 8'h00, 57); run_op(23'h224, SB, -1);
        // R1: second start during a read.
        set_card(1, 1, 1, 8'h00, 77); run_op(23'h333, -1, 60);
        // R9: SCLK high phase length.
        chk(hi_min == HALF && hi_max == HALF, "R9 sclk high length", hi_max, HALF);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule